// File: doc/BRIEF.md
# Clean Writeback Filter Table

This block sits beside a private L2 cache and decides, for every line the L2 evicts, whether the line has to be sent to the victim L3 or whether the transfer can be skipped. Modified lines always travel to L3. Clean lines are checked against a small history of addresses that are probably already held by L3. A clean line found in the history has its writeback squashed. A clean line not found is forwarded, and its address is recorded so that a later eviction of the same line can be squashed.

The history is a set-associative tag store. It has far fewer entries than the cache has lines, and each set uses true LRU replacement. A snoop response from L3 reporting that a line is present can also place that address into the history. The history is only a hint. A stale entry, such as one for a line that L3 has since dropped, costs a later memory fetch and never leads to a correctness fault. For this reason the block has no error output.

Requests arrive through one port that has a ready signal. Eviction requests take priority over snoop notices. Each accepted eviction receives exactly one registered decision in the next cycle. A clear input empties the history.

Top module: `clean_wb_filter`

## Requirements
- R1: After a synchronous reset, `dec_valid` is low, `req_ready` is high and the history holds no entries, so the first clean eviction of any address is forwarded.
- R2: An eviction with `evict_dirty`=1 always gives `dec_forward`=1 and leaves the history unchanged. A later clean eviction of the same address is therefore treated as a miss.
- R3: A clean eviction whose address is not in the history gives `dec_forward`=1 and records the address.
- R4: A clean eviction whose address is in the history gives `dec_forward`=0 (squash) and marks that entry most recently used.
- R5: An eviction accepted at a clock edge (`evict_valid` and `req_ready` both high) raises `dec_valid` for exactly the following cycle. `req_ready` is low in that cycle.
- R6: Each set holds WAYS addresses. An empty way is filled first, lowest way number first. When the set is full, the least recently used address is replaced, where both allocation and hits count as use.
- R7: An accepted snoop notice (`snoop_valid` high with `evict_valid` low) records `snoop_addr` in the history or refreshes its entry. It produces no decision.
- R8: While `clear` is high, `req_ready` is low. A clear empties the whole history.
- R9: If an eviction and a snoop notice are offered in the same cycle, the eviction is taken first. The snoop notice must stay asserted and is accepted later.
- R10: The set index is the low log2(SETS) bits of the line address, and the remaining bits form the tag. Addresses with different indexes never evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Empty the history table |
| evict_valid | input | 1 | Eviction request offered |
| evict_addr | input | ADDR_W | Line address of the evicted line |
| evict_dirty | input | 1 | Evicted line is modified |
| snoop_valid | input | 1 | L3-present snoop notice offered |
| snoop_addr | input | ADDR_W | Line address reported present in L3 |
| req_ready | output | 1 | A request can be accepted this cycle |
| dec_valid | output | 1 | Decision valid (one cycle per eviction) |
| dec_forward | output | 1 | 1 = forward to L3, 0 = squash |

## Verification
The bench fills one set beyond its capacity after a hit has reordered it. A design that replaced the oldest allocation, or did not refresh on a hit, would forward a line that should be squashed, or squash one whose entry had already been evicted. Dirty evictions of addresses that are already in the table are checked for forwarding, and dirty evictions of new addresses are checked for leaving no trace. A design that allocated on dirty lines would squash the following clean eviction. A same-cycle eviction and snoop notice checks that the snoop is neither lost nor answered with a stray decision, and a clear in mid-run checks that no old entry survives it.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  // Kind of request accepted in a given cycle
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_EVICT = 2'd1,
    REQ_SNOOP = 2'd2
  } req_kind_e;
endpackage

// File: rtl/cwf_set_match.sv
module cwf_set_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 25,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [TAG_W-1:0] look_tag,
  input  logic [TAG_W-1:0] way_tag [WAYS],
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAY_W-1:0] way_age [WAYS],
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAYS-1:0] match_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = way_valid[w] && (way_tag[w] == look_tag);
  end

  always_comb begin
    hit     = |match_vec;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match_vec[w]) hit_way = WAY_W'(w);
  end

  // Empty way with the lowest number first, otherwise the oldest way
  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_age[w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!way_valid[w]) victim_way = WAY_W'(w);
  end
endmodule

// File: rtl/cwf_lru_age.sv
module cwf_lru_age #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAY_W-1:0] age_in  [WAYS],
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] age_out [WAYS]
);
  // Age 0 is most recent and WAYS-1 is oldest. The ages of a set always form a permutation.
  logic [WAY_W-1:0] touched_age;
  assign touched_age = age_in[touch_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    always_comb begin
      if (WAY_W'(w) == touch_way)      age_out[w] = '0;
      else if (age_in[w] < touched_age) age_out[w] = age_in[w] + 1'b1;
      else                              age_out[w] = age_in[w];
    end
  end
endmodule

// File: rtl/clean_wb_filter.sv
module clean_wb_filter #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              evict_dirty,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              req_ready,
  output logic              dec_valid,
  output logic              dec_forward
);
  import cwf_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] tag_mem   [SETS][WAYS];
  logic [WAY_W-1:0] age_mem   [SETS][WAYS];
  logic [WAYS-1:0]  valid_mem [SETS];

  logic busy_q;
  req_kind_e kind;
  logic [ADDR_W-1:0] sel_addr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [TAG_W-1:0]  set_tag [WAYS];
  logic [WAY_W-1:0]  set_age [WAYS];
  logic [WAY_W-1:0]  new_age [WAYS];
  logic [WAYS-1:0]   set_valid;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, victim_way, touch_way;
  logic              do_update;

  assign req_ready = !busy_q && !clear;

  always_comb begin
    kind = REQ_NONE;
    if (req_ready && evict_valid)      kind = REQ_EVICT;
    else if (req_ready && snoop_valid) kind = REQ_SNOOP;
  end

  assign sel_addr = evict_valid ? evict_addr : snoop_addr;
  assign idx      = sel_addr[IDX_W-1:0];
  assign tag      = sel_addr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign set_tag[w] = tag_mem[idx][w];
    assign set_age[w] = age_mem[idx][w];
  end
  assign set_valid = valid_mem[idx];

  cwf_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .look_tag  (tag),
    .way_tag   (set_tag),
    .way_valid (set_valid),
    .way_age   (set_age),
    .hit       (hit),
    .hit_way   (hit_way),
    .victim_way(victim_way)
  );

  assign touch_way = hit ? hit_way : victim_way;

  cwf_lru_age #(.WAYS(WAYS)) u_lru (
    .age_in   (set_age),
    .touch_way(touch_way),
    .age_out  (new_age)
  );

  assign do_update = (kind == REQ_SNOOP) || (kind == REQ_EVICT && !evict_dirty);

  // Tag array: no reset, one write port
  always_ff @(posedge clk) begin
    if (!rst && !clear && do_update)
      tag_mem[idx][touch_way] <= tag;
  end

  // Valid bits and ages
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int s = 0; s < SETS; s++) begin
        valid_mem[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_mem[s][w] <= WAY_W'(w);
      end
    end else if (do_update) begin
      valid_mem[idx][touch_way] <= 1'b1;
      for (int w = 0; w < WAYS; w++) age_mem[idx][w] <= new_age[w];
    end
  end

  // Decision and handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      dec_valid   <= 1'b0;
      dec_forward <= 1'b0;
    end else begin
      busy_q    <= (kind != REQ_NONE);
      dec_valid <= (kind == REQ_EVICT);
      if (kind == REQ_EVICT) dec_forward <= evict_dirty || !hit;
    end
  end
endmodule

// File: rtl/cwf_checker.sv
module cwf_checker (
  input logic clk,
  input logic rst,
  input logic clear,
  input logic evict_valid,
  input logic evict_dirty,
  input logic snoop_valid,
  input logic req_ready,
  input logic dec_valid,
  input logic dec_forward
);
  logic ev_take, sn_take;
  assign ev_take = evict_valid && req_ready;
  assign sn_take = snoop_valid && !evict_valid && req_ready;

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !dec_valid);

  p_decision_next_r5: assert property (@(posedge clk) disable iff (rst)
    ev_take |=> dec_valid);

  p_decision_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  p_ready_low_r5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !req_ready);

  p_dirty_forward_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_take && evict_dirty) |=> (dec_valid && dec_forward));

  p_snoop_silent_r7: assert property (@(posedge clk) disable iff (rst)
    sn_take |=> !dec_valid);

  p_clear_stall_r8: assert property (@(posedge clk) disable iff (rst)
    clear |-> !req_ready);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    !ev_take |=> !dec_valid);
endmodule

bind clean_wb_filter cwf_checker u_cwf_checker (
  .clk        (clk),
  .rst        (rst),
  .clear      (clear),
  .evict_valid(evict_valid),
  .evict_dirty(evict_dirty),
  .snoop_valid(snoop_valid),
  .req_ready  (req_ready),
  .dec_valid  (dec_valid),
  .dec_forward(dec_forward)
);

// File: tb/clean_wb_filter_bench.sv
`timescale 1ns/1ps
module clean_wb_filter_bench;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0;
  logic evict_valid = 1'b0;
  logic [ADDR_W-1:0] evict_addr = '0;
  logic evict_dirty = 1'b0;
  logic snoop_valid = 1'b0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic req_ready, dec_valid, dec_forward;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit    exp_q[$];
  string req_q[$];

  always #5 clk = ~clk;

  clean_wb_filter u_clean_wb_filter (
    .clk(clk), .rst(rst), .clear(clear),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_dirty(evict_dirty),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .req_ready(req_ready), .dec_valid(dec_valid), .dec_forward(dec_forward)
  );

  // Index is the low 7 bits for 128 sets
  function automatic logic [ADDR_W-1:0] mk(int t, int ix);
    return (ADDR_W'(t) << 7) | ADDR_W'(ix);
  endfunction

  task automatic check(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic evict(logic [ADDR_W-1:0] a, bit dirty, bit exp_fwd, string r);
    wait_ready();
    evict_valid = 1'b1; evict_addr = a; evict_dirty = dirty;
    exp_q.push_back(exp_fwd); req_q.push_back(r);
    @(negedge clk);
    evict_valid = 1'b0;
    check(dec_valid && !req_ready, "R5 decision timing", {dec_valid, req_ready}, 2);
  endtask

  task automatic snoop(logic [ADDR_W-1:0] a);
    wait_ready();
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
    check(!dec_valid, "R7 no decision for snoop", dec_valid, 0);
  endtask

  // Monitor: pops expected decisions
  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected decision", 1, 0);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(dec_forward == e, r, dec_forward, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!dec_valid, "R1 dec_valid after reset", dec_valid, 0);
    check(req_ready, "R1 ready after reset", req_ready, 1);

    // R1/R3/R4: miss then hit
    evict(mk(3, 1), 0, 1, "R1 first clean evict forwards");
    evict(mk(3, 1), 0, 0, "R4 clean hit squashes");

    // R2: dirty never allocates, always forwards
    evict(mk(7, 2), 1, 1, "R2 dirty forwards");
    evict(mk(7, 2), 0, 1, "R2 dirty left no entry");
    evict(mk(7, 2), 0, 0, "R3 clean miss allocated");
    evict(mk(3, 1), 1, 1, "R2 dirty forwards despite entry");
    evict(mk(3, 1), 0, 0, "R2 entry unchanged by dirty");

    // R6: LRU in set 9
    for (int t = 1; t <= 4; t++) evict(mk(t, 9), 0, 1, "R6 fill set");
    evict(mk(1, 9), 0, 0, "R6 hit refreshes");
    evict(mk(5, 9), 0, 1, "R6 fifth tag allocates");
    evict(mk(2, 9), 0, 1, "R6 LRU tag was replaced");
    evict(mk(1, 9), 0, 0, "R6 refreshed tag kept");
    evict(mk(4, 9), 0, 0, "R6 older tag kept");
    evict(mk(3, 9), 0, 1, "R6 tag 3 was replaced");

    // R10: same tag, other set
    evict(mk(1, 10), 0, 1, "R10 other index independent");
    evict(mk(1, 9), 0, 0, "R10 set 9 untouched");

    // R7: snoop insertion
    snoop(mk(40, 20));
    evict(mk(40, 20), 0, 0, "R7 snooped line squashed");

    // R9: eviction beats snoop
    wait_ready();
    evict_valid = 1'b1; evict_addr = mk(50, 30); evict_dirty = 1'b0;
    snoop_valid = 1'b1; snoop_addr = mk(51, 31);
    exp_q.push_back(1'b1); req_q.push_back("R9 eviction first");
    @(negedge clk);
    evict_valid = 1'b0;
    check(!req_ready, "R9 busy after eviction", req_ready, 0);
    @(negedge clk);
    check(req_ready, "R9 ready for held snoop", req_ready, 1);
    @(negedge clk);
    check(!dec_valid, "R9 snoop gives no decision", dec_valid, 0);
    snoop_valid = 1'b0;
    evict(mk(51, 31), 0, 0, "R9 held snoop recorded");

    // R8: clear
    wait_ready();
    clear = 1'b1;
    #1;
    check(!req_ready, "R8 ready low during clear", req_ready, 0);
    @(negedge clk);
    clear = 1'b0;
    evict(mk(3, 1), 0, 1, "R8 entry gone after clear");
    evict(mk(40, 20), 0, 1, "R8 snooped entry gone");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 every eviction decided", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule